// File: doc/BRIEF.md
# Receive Buffer Flow-Control Watermark Controller

This block sits beside a receive FIFO and decides when the link partner should be told to stop and when it may resume. It compares the FIFO fill level, given in bytes, against two programmable thresholds. Both thresholds are expressed in 8-byte units. When the fill level climbs to the upper threshold, the block asks the transmit path to send a stop request that carries a programmable pause time. When the fill level has drained down to the lower threshold, it asks for a resume request, which is a stop request with a pause time of zero. The gap between the two thresholds gives hysteresis, so a FIFO that hovers near one level does not produce a stream of requests.

While traffic is held, the block repeats the stop request before the advertised pause time can run out. Pause time is measured in slots of 512 bit times, and the MAC supplies a one-cycle strobe for each slot. Each request waits on a valid/ready handshake until the transmit side takes it. A later request of the opposite kind cancels a request that has not yet been taken. Flow control is active only when the enable bit is set and the upper threshold is not zero. Software normally places the upper threshold 128 units (1 KB) above the lower one and uses 0xF000 as the pause time. Building the pause frame and storing the received data are handled outside this block.

Top module: `rxq_pause_ctrl`

## Requirements
- R1: After reset, `xoff_valid` and `xon_valid` are 0 and `xoff_quanta` is 0.
- R2: When flow control is active and the block is not holding traffic, a fill level of at least `wm_high`×8 bytes raises `xoff_valid` one clock later, with `xoff_quanta` equal to the `quanta_cfg` value sampled at that edge. A fill level of `wm_high`×8−1 bytes raises nothing.
- R3: While `wm_high` is 0, no stop request is raised, whatever the fill level.
- R4: While `pause_en` is 0, no stop request is raised, whatever the fill level.
- R5: While traffic is held, a fill level strictly between the two thresholds raises no request. A fill level of at most `wm_low`×8 bytes ends the hold and raises `xon_valid` one clock later. `xon_quanta` is always 0.
- R6: A raised request stays valid until the edge at which its ready input is high. It reads 0 one clock after that handshake, unless a new request of the same kind is raised at that edge.
- R7: `xoff_valid` and `xon_valid` are never high together. A resume request cancels a pending stop request, and a stop request cancels a pending resume request.
- R8: While traffic is held and no stop request is pending, slot strobes are counted. On the strobe that brings the count to max(floor(q/2),1), where q is the pause time of the last stop request, a fresh stop request is raised. That request carries the current `quanta_cfg` and restarts the count.
- R9: If flow control becomes inactive (`pause_en` cleared or `wm_high` set to 0) while traffic is held, the hold ends and a resume request is raised one clock later.
- R10: `xoff_quanta` stays stable while a stop request waits for its handshake, even if `quanta_cfg` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_occ | input | OCC_W | Receive FIFO fill level in bytes |
| wm_low | input | WM_W | Resume threshold in 8-byte units |
| wm_high | input | WM_W | Stop threshold in 8-byte units; 0 turns flow control off |
| pause_en | input | 1 | Enable for sending flow-control requests |
| quanta_cfg | input | QNT_W | Pause time placed in stop requests, in slot units |
| slot_tick | input | 1 | One-cycle strobe per 512-bit-time slot |
| xoff_valid | output | 1 | Stop request pending |
| xoff_ready | input | 1 | Transmit side takes the stop request |
| xoff_quanta | output | QNT_W | Pause time carried by the stop request |
| xon_valid | output | 1 | Resume request pending |
| xon_ready | input | 1 | Transmit side takes the resume request |
| xon_quanta | output | QNT_W | Pause time of the resume request, always 0 |

## Verification
The bench drives the fill level exactly one byte short of each threshold and then exactly onto it. A design that compares in the wrong unit, or uses a strict comparison, would raise its request one byte late or one byte early. It also covers a zero upper threshold and a cleared enable. A design that ignores either would send stop requests when it should be silent, or would keep traffic held after flow control was switched off. It checks that opposite requests cancel each other and that the pause time is frozen while a request waits for its handshake. A wrong design would show both valids high at once, or would send a pause time taken from a later configuration. The refresh count is tested with small pause times, including 1. An off-by-one in the count, or counting strobes while a request is still pending, moves the repeated stop request by one slot, and the bench's own reference model catches that during a long random walk of the fill level.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

  typedef enum logic [0:0] {
    ST_FLOW = 1'b0,
    ST_HELD = 1'b1
  } pstate_t;

  // threshold in 8-byte units converted to a byte count
  function automatic logic [31:0] wm_to_bytes(input logic [31:0] wm);
    return wm << 3;
  endfunction

  // slot count after which a held link gets a fresh stop request
  function automatic logic [31:0] refresh_limit(input logic [31:0] q);
    logic [31:0] half;
    half = q >> 1;
    return (half == 32'd0) ? 32'd1 : half;
  endfunction

endpackage

// File: rtl/rpw_level_cmp.sv
module rpw_level_cmp #(
  parameter int OCC_W = 18,
  parameter int WM_W  = 15
) (
  input  logic [OCC_W-1:0] occ,
  input  logic [WM_W-1:0]  wm_low,
  input  logic [WM_W-1:0]  wm_high,
  input  logic             pause_en,
  output logic             fc_on,
  output logic             hi_hit,
  output logic             lo_hit
);
  import rpw_pkg::*;

  localparam int OCC_PAD = 32 - OCC_W;
  localparam int WM_PAD  = 32 - WM_W;

  logic [31:0] occ_x, hi_bytes, lo_bytes;

  always_comb begin
    occ_x    = {{OCC_PAD{1'b0}}, occ};
    hi_bytes = wm_to_bytes({{WM_PAD{1'b0}}, wm_high});
    lo_bytes = wm_to_bytes({{WM_PAD{1'b0}}, wm_low});
    fc_on    = pause_en && (wm_high != '0);
    hi_hit   = occ_x >= hi_bytes;
    lo_hit   = occ_x <= lo_bytes;
  end

endmodule

// File: rtl/rpw_req_slot.sv
module rpw_req_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic drop,
  input  logic ready,
  output logic valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                valid <= 1'b0;
    else if (set)              valid <= 1'b1;
    else if (drop)             valid <= 1'b0;
    else if (valid && ready)   valid <= 1'b0;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !drop) |=> valid); // R6

  AST_REQ_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !set) |=> !valid); // R6

endmodule

// File: rtl/rpw_refresh_timer.sv
module rpw_refresh_timer #(
  parameter int QNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [QNT_W-1:0] last_q,
  output logic             fire
);
  import rpw_pkg::*;

  localparam int Q_PAD = 32 - QNT_W;

  logic [QNT_W-1:0] cnt;
  logic [31:0]      limit;
  logic [31:0]      cnt_next_x;
  logic             reached;

  always_comb begin
    limit      = refresh_limit({{Q_PAD{1'b0}}, last_q});
    cnt_next_x = {{Q_PAD{1'b0}}, cnt} + 32'd1;
    reached    = cnt_next_x >= limit;
    fire       = run && tick && reached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || fire)  cnt <= '0;
    else if (run && tick)    cnt <= cnt + 1'b1;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ({{Q_PAD{1'b0}}, cnt} < limit)); // R8

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0)); // R8

endmodule

// File: rtl/rxq_pause_ctrl.sv
module rxq_pause_ctrl #(
  parameter int OCC_W = 18,
  parameter int WM_W  = 15,
  parameter int QNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] fifo_occ,
  input  logic [WM_W-1:0]  wm_low,
  input  logic [WM_W-1:0]  wm_high,
  input  logic             pause_en,
  input  logic [QNT_W-1:0] quanta_cfg,
  input  logic             slot_tick,
  output logic             xoff_valid,
  input  logic             xoff_ready,
  output logic [QNT_W-1:0] xoff_quanta,
  output logic             xon_valid,
  input  logic             xon_ready,
  output logic [QNT_W-1:0] xon_quanta
);
  import rpw_pkg::*;

  pstate_t state;
  logic    fc_on, hi_hit, lo_hit;
  logic    ev_start, ev_release, ev_refire, xoff_set;
  logic    tmr_clear, tmr_run;

  rpw_level_cmp #(.OCC_W(OCC_W), .WM_W(WM_W)) u_cmp (
    .occ      (fifo_occ),
    .wm_low   (wm_low),
    .wm_high  (wm_high),
    .pause_en (pause_en),
    .fc_on    (fc_on),
    .hi_hit   (hi_hit),
    .lo_hit   (lo_hit)
  );

  always_comb begin
    ev_start   = (state == ST_FLOW) && fc_on && hi_hit;
    ev_release = (state == ST_HELD) && (!fc_on || lo_hit);
    tmr_clear  = (state == ST_FLOW) || ev_release;
    tmr_run    = (state == ST_HELD) && !ev_release && !xoff_valid;
    xoff_set   = ev_start || ev_refire;
  end

  rpw_refresh_timer #(.QNT_W(QNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_clear),
    .run    (tmr_run),
    .tick   (slot_tick),
    .last_q (xoff_quanta),
    .fire   (ev_refire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state <= ST_FLOW;
    else if (ev_start)   state <= ST_HELD;
    else if (ev_release) state <= ST_FLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        xoff_quanta <= '0;
    else if (xoff_set) xoff_quanta <= quanta_cfg;
  end

  rpw_req_slot u_xoff (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (xoff_set),
    .drop  (ev_release),
    .ready (xoff_ready),
    .valid (xoff_valid)
  );

  rpw_req_slot u_xon (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_release),
    .drop  (ev_start),
    .ready (xon_ready),
    .valid (xon_valid)
  );

  assign xon_quanta = '0;

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(xoff_valid && xon_valid)); // R7

  AST_START_NEEDS_FC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> (pause_en && (wm_high != '0))); // R3

  AST_QUANTA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_valid && !xoff_ready && !ev_release) |=> $stable(xoff_quanta)); // R10

  AST_XON_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xon_valid) |-> (state == ST_FLOW && $past(state) == ST_HELD)); // R5

  AST_REFIRE_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refire |-> (state == ST_HELD && !xoff_valid)); // R8

endmodule

// File: tb/rxq_pause_ctrl_bench.sv
module rxq_pause_ctrl_bench;
  localparam int OCC_W = 18, WM_W = 15, QNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [OCC_W-1:0] fifo_occ = '0;
  logic [WM_W-1:0]  wm_low = '0, wm_high = '0;
  logic             pause_en = 1'b0, slot_tick = 1'b0;
  logic [QNT_W-1:0] quanta_cfg = '0;
  logic             xoff_ready = 1'b0, xon_ready = 1'b0;
  logic             xoff_valid, xon_valid;
  logic [QNT_W-1:0] xoff_quanta, xon_quanta;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference state
  bit m_p, m_xoff, m_xon;
  int m_q, m_cnt;

  always #5 clk = ~clk;

  rxq_pause_ctrl #(.OCC_W(OCC_W), .WM_W(WM_W), .QNT_W(QNT_W)) u_rxq_pause_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_occ(fifo_occ), .wm_low(wm_low), .wm_high(wm_high),
    .pause_en(pause_en), .quanta_cfg(quanta_cfg), .slot_tick(slot_tick),
    .xoff_valid(xoff_valid), .xoff_ready(xoff_ready), .xoff_quanta(xoff_quanta),
    .xon_valid(xon_valid), .xon_ready(xon_ready), .xon_quanta(xon_quanta));

  function automatic int limit_of(int q);
    return (q / 2 < 1) ? 1 : q / 2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance the reference by one edge using the inputs held now
  task automatic model_edge();
    bit fc, hi, lo, st, rel, ref_f;
    fc    = pause_en && (wm_high != 0);
    hi    = int'(fifo_occ) >= int'(wm_high) * 8;
    lo    = int'(fifo_occ) <= int'(wm_low) * 8;
    st    = !m_p && fc && hi;
    rel   = m_p && (!fc || lo);
    ref_f = m_p && !rel && !m_xoff && slot_tick && (m_cnt + 1 >= limit_of(m_q));
    if (!m_p || rel || ref_f) m_cnt = 0;
    else if (!m_xoff && slot_tick) m_cnt = m_cnt + 1;
    if (st || ref_f) m_q = int'(quanta_cfg);
    if (st || ref_f) m_xoff = 1;
    else if (rel) m_xoff = 0;
    else if (m_xoff && xoff_ready) m_xoff = 0;
    if (rel) m_xon = 1;
    else if (st) m_xon = 0;
    else if (m_xon && xon_ready) m_xon = 0;
    if (st) m_p = 1;
    else if (rel) m_p = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic cmp_model(string tag);
    chk({tag, " xoff_valid"}, int'(xoff_valid), int'(m_xoff));
    chk({tag, " xon_valid"}, int'(xon_valid), int'(m_xon));
    chk({tag, " xoff_quanta"}, int'(xoff_quanta), m_q);
    chk({tag, " R5 xon_quanta"}, int'(xon_quanta), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int occ_i;
    m_p = 0; m_xoff = 0; m_xon = 0; m_q = 0; m_cnt = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 xoff_valid", int'(xoff_valid), 0);
    chk("R1 xon_valid", int'(xon_valid), 0);
    chk("R1 xoff_quanta", int'(xoff_quanta), 0);
    rst_n = 1'b1;
    wm_low = 15'd100; wm_high = 15'd228; pause_en = 1'b1; quanta_cfg = 16'hF000;

    // R2 boundary one byte short, then exactly on the mark
    fifo_occ = 18'(228*8 - 1); step(); step();
    chk("R2 below mark", int'(xoff_valid), 0);
    fifo_occ = 18'(228*8); step();
    chk("R2 at mark valid", int'(xoff_valid), 1);
    chk("R2 at mark quanta", int'(xoff_quanta), 16'hF000);

    // R6/R10 held without ready, config changes
    quanta_cfg = 16'h0123;
    step(); step(); step();
    chk("R6 held valid", int'(xoff_valid), 1);
    chk("R10 quanta frozen", int'(xoff_quanta), 16'hF000);
    xoff_ready = 1'b1; step(); xoff_ready = 1'b0;
    chk("R6 retired", int'(xoff_valid), 0);

    // R5 hysteresis band then low mark
    fifo_occ = 18'(100*8 + 1); step(); step();
    chk("R5 band xoff", int'(xoff_valid), 0);
    chk("R5 band xon", int'(xon_valid), 0);
    fifo_occ = 18'(100*8); step();
    chk("R5 xon raised", int'(xon_valid), 1);
    chk("R5 xon quanta", int'(xon_quanta), 0);
    xon_ready = 1'b1; step(); xon_ready = 1'b0;
    chk("R6 xon retired", int'(xon_valid), 0);

    // R3 zero high mark
    wm_high = '0; fifo_occ = '1; step(); step(); step();
    chk("R3 no xoff", int'(xoff_valid), 0);
    // R4 enable cleared
    wm_high = 15'd228; pause_en = 1'b0; step(); step(); step();
    chk("R4 no xoff", int'(xoff_valid), 0);

    // R7 replacement both ways
    pause_en = 1'b1; quanta_cfg = 16'd50; step();
    chk("R7 xoff up", int'(xoff_valid), 1);
    fifo_occ = '0; step();
    chk("R7 xon replaces xoff", int'(xon_valid), 1);
    chk("R7 xoff cancelled", int'(xoff_valid), 0);
    fifo_occ = '1; step();
    chk("R7 xoff replaces xon", int'(xoff_valid), 1);
    chk("R7 xon cancelled", int'(xon_valid), 0);
    fifo_occ = '0; step();
    xon_ready = 1'b1; step(); xon_ready = 1'b0;

    // R8 refresh with q=6 -> limit 3
    quanta_cfg = 16'd6; fifo_occ = 18'(150*8); step();
    chk("R8 hold stays in band", int'(xoff_valid), 0);
    fifo_occ = 18'(228*8); step();
    chk("R8 first xoff", int'(xoff_valid), 1);
    fifo_occ = 18'(150*8);
    slot_tick = 1'b1; step(); step();
    chk("R8 ticks while pending ignored", int'(xoff_valid), 1);
    slot_tick = 1'b0; xoff_ready = 1'b1; step(); xoff_ready = 1'b0;
    quanta_cfg = 16'd1;
    slot_tick = 1'b1; step(); step();
    chk("R8 two ticks no refresh", int'(xoff_valid), 0);
    step(); slot_tick = 1'b0;
    chk("R8 third tick refresh", int'(xoff_valid), 1);
    chk("R8 refresh quanta", int'(xoff_quanta), 1);
    xoff_ready = 1'b1; step(); xoff_ready = 1'b0;
    slot_tick = 1'b1; step(); slot_tick = 1'b0;
    chk("R8 limit one refresh", int'(xoff_valid), 1);
    xoff_ready = 1'b1; step(); xoff_ready = 1'b0;

    // R9 flow control switched off while held
    pause_en = 1'b0; step();
    chk("R9 xon on disable", int'(xon_valid), 1);
    xon_ready = 1'b1; step(); xon_ready = 1'b0;
    cmp_model("R9 sync");

    // random walk against the reference
    pause_en = 1'b1; wm_low = 15'd20; wm_high = 15'd40; occ_i = 200;
    for (int i = 0; i < 4000; i++) begin
      occ_i = occ_i + int'($urandom_range(60)) - 30;
      if (occ_i < 0) occ_i = 0;
      if (occ_i > 420) occ_i = 420;
      fifo_occ   = 18'(occ_i);
      xoff_ready = ($urandom_range(99) < 40);
      xon_ready  = ($urandom_range(99) < 40);
      slot_tick  = ($urandom_range(99) < 35);
      quanta_cfg = 16'($urandom_range(20));
      if ($urandom_range(99) < 2) pause_en = ~pause_en;
      if ($urandom_range(199) < 2) wm_high = (wm_high == 0) ? 15'd40 : 15'd0;
      step();
      cmp_model("R2 R5 R7 R8 model");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule